// File: doc/BRIEF.md
# Buffered-Compare Interval Timer

This block is an up-counting interval timer that advances only on cycles where a count-clock enable is high. Software sets a period value and a match value through a small register write port. Each value is copied into a shadow buffer, and the counter compares against the shadow copies, never against the written registers. The buffers refill while the timer is stopped and again at every period boundary. A write made in the middle of a period therefore takes effect only from the next period on.

When the counter reaches the buffered period value, it returns to zero on the next enabled count and issues a one-cycle period pulse. When the counter equals the buffered match value on an enabled count, a toggle output inverts and a match pulse is issued. Software can mask the match pulse without stopping the toggle. If the match value equals the period value, the toggle output is a square wave with 50% duty. When the match channel is not used, the all-ones value keeps it quiet.

A read port returns the written registers and the live counter value.

Top module: `interval_timer`

## Requirements
- R1: Read address 3 returns the live counter value. Address 0 returns the period register and address 1 returns the match register. Address 2 returns the control bits: bit 0 is run and bit 1 is the match-pulse mask. All other read bits are zero.
- R2: While running, the counter steps 0, 1, … P on enabled cycles and returns to 0 after P, where P is the buffered period value. The interval is therefore P+1 enabled counts.
- R3: On each enabled count at which the counter equals the buffered period value, irq_period is high for exactly one cycle, in the cycle that follows that clock edge.
- R4: Both buffers load the written register values on every clock edge while the timer is stopped, and while running only at the edge where the counter wraps. A mid-period write changes nothing before the next wrap.
- R5: On each enabled count at which the counter equals the buffered match value, toggle_out inverts at that clock edge.
- R6: On that same event, irq_cmp1 is high for one cycle unless the mask is set.
- R7: If the match value equals the period value, toggle_out is high for exactly half of the cycles over any whole number of its own periods.
- R8: The mask suppresses only irq_cmp1. toggle_out keeps inverting while the mask is set.
- R9: A cleared run bit forces the counter to 0 and toggle_out low and suppresses both pulses. Setting run again restarts the count from 0.
- R10: After reset, both compare registers hold all ones and both control bits are 0.
- R11: While running, a low cnt_en holds the counter and produces no pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en | input | 1 | Count-clock enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 period, 1 match, 2 control |
| wr_data | input | CNT_W | Write data |
| rd_addr | input | 2 | Read address: 0 period, 1 match, 2 control, 3 counter |
| rd_data | output | CNT_W | Read data, combinational from rd_addr |
| toggle_out | output | 1 | Match-driven toggle output |
| irq_period | output | 1 | One-cycle period pulse |
| irq_cmp1 | output | 1 | One-cycle maskable match pulse |

## Verification
The bench builds the timer with CNT_W set to 8. This brings the all-ones "unused" match setting and the largest possible period (256 counts) within reach of short random runs.

Random period and match values stay mostly below 12. As a result, wraps, mid-period writes that must wait for the buffer reload, and matches placed beyond the period all occur many times. Stops and restarts occur as well.

Directed runs measure the interval, the duty cycle of equal compares, and the toggling that continues under the mask.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int ADDR_W    = 2;
    localparam int CTRL_RUN  = 0;
    localparam int CTRL_MASK = 1;

    typedef enum logic [ADDR_W-1:0] {
        A_PERIOD = 2'd0,
        A_MATCH  = 2'd1,
        A_CTRL   = 2'd2,
        A_COUNT  = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [CNT_W-1:0]  period_o,
    output logic [CNT_W-1:0]  match_o,
    output logic              run_o,
    output logic              mask_o
);
    typedef struct packed {
        logic [CNT_W-1:0] period;
        logic [CNT_W-1:0] match;
        logic             run;
        logic             mask;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                A_PERIOD: r_d.period = wr_data;
                A_MATCH:  r_d.match  = wr_data;
                A_CTRL: begin
                    r_d.run  = wr_data[CTRL_RUN];
                    r_d.mask = wr_data[CTRL_MASK];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.period <= '1;
            r_q.match  <= '1;
            r_q.run    <= 1'b0;
            r_q.mask   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign period_o = r_q.period;
    assign match_o  = r_q.match;
    assign run_o    = r_q.run;
    assign mask_o   = r_q.mask;

    // R10
    reset_cfg_chk: assert property (@(posedge clk) $rose(rst_n) |-> (r_q.period == '1 && !r_q.run));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             cnt_en_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] match_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             hit_o,
    output logic             wrap_irq_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] buf0;
        logic [CNT_W-1:0] buf1;
        logic             irq;
    } cnt_t;

    cnt_t s_d, s_q;
    logic wrap;

    assign wrap  = run_i && cnt_en_i && (s_q.cnt == s_q.buf0);
    assign hit_o = run_i && cnt_en_i && (s_q.cnt == s_q.buf1);

    always_comb begin
        s_d     = s_q;
        s_d.irq = wrap;
        if (!run_i) begin
            s_d.cnt  = '0;
            s_d.buf0 = period_i;
            s_d.buf1 = match_i;
        end else if (cnt_en_i) begin
            if (wrap) begin
                s_d.cnt  = '0;
                s_d.buf0 = period_i;
                s_d.buf1 = match_i;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.cnt  <= '0;
            s_q.buf0 <= '1;
            s_q.buf1 <= '1;
            s_q.irq  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt_o      = s_q.cnt;
    assign wrap_irq_o = s_q.irq;

    // R3
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n) s_q.irq |-> (s_q.cnt == '0));
    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) s_q.cnt <= s_q.buf0);
    // R11
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && $past(run_i) && !$past(cnt_en_i)) |-> $stable(s_q.cnt));
    // R4
    buf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run_i) && !s_q.irq) |-> ($stable(s_q.buf0) && $stable(s_q.buf1)));
endmodule

// File: rtl/tmr_toggle.sv
module tmr_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic hit_i,
    input  logic mask_i,
    output logic tog_o,
    output logic irq_o
);
    typedef struct packed {
        logic tog;
        logic irq;
    } tog_t;

    tog_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (!run_i) begin
            t_d.tog = 1'b0;
            t_d.irq = 1'b0;
        end else begin
            t_d.tog = t_q.tog ^ hit_i;
            t_d.irq = hit_i && !mask_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign tog_o = t_q.tog;
    assign irq_o = t_q.irq;

    // R9
    stop_low_chk: assert property (@(posedge clk) disable iff (!rst_n) !run_i |=> !t_q.tog);
    // R8
    mask_chk: assert property (@(posedge clk) disable iff (!rst_n) t_q.irq |-> !$past(mask_i));
    // R6
    irq_flip_chk: assert property (@(posedge clk) disable iff (!rst_n) t_q.irq |-> (t_q.tog != $past(t_q.tog)));
endmodule

// File: rtl/interval_timer.sv
module interval_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data,
    output logic             toggle_out,
    output logic             irq_period,
    output logic             irq_cmp1
);
    logic [CNT_W-1:0] period, match, cnt;
    logic             run, mask, hit;

    tmr_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .period_o(period), .match_o(match), .run_o(run), .mask_o(mask)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run_i(run), .cnt_en_i(cnt_en),
        .period_i(period), .match_i(match),
        .cnt_o(cnt), .hit_o(hit), .wrap_irq_o(irq_period)
    );

    tmr_toggle u_tog (
        .clk(clk), .rst_n(rst_n), .run_i(run), .hit_i(hit), .mask_i(mask),
        .tog_o(toggle_out), .irq_o(irq_cmp1)
    );

    always_comb begin
        rd_data = '0;
        case (reg_addr_e'(rd_addr))
            A_PERIOD: rd_data = period;
            A_MATCH:  rd_data = match;
            A_CTRL: begin
                rd_data[CTRL_RUN]  = run;
                rd_data[CTRL_MASK] = mask;
            end
            A_COUNT:  rd_data = cnt;
            default:  rd_data = '0;
        endcase
    end

    // R1
    ctrl_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == 2'd2) |-> (rd_data[CNT_W-1:2] == '0));
endmodule

// File: tb/interval_timer_tb.sv
`timescale 1ns/1ps
module interval_timer_tb;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cnt_en = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic [1:0]   rd_addr = '0;
    logic [W-1:0] rd_data;
    logic         toggle_out, irq_period, irq_cmp1;

    int checks = 0;
    int errors = 0;
    bit chk_on = 1'b0;
    bit done = 1'b0;

    // measurement windows
    bit win = 1'b0;
    int w_hi, w_p, w_c1, w_flip;
    logic prev_tog = 1'b0;

    // reference state
    logic [W-1:0] m_cmp0, m_cmp1, m_buf0, m_buf1, m_cnt;
    logic m_run, m_mask, m_tog, m_irq0, m_irq1;

    always #4 clk = ~clk;

    interval_timer #(.CNT_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .toggle_out(toggle_out), .irq_period(irq_period), .irq_cmp1(irq_cmp1)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] exp_read(input logic [1:0] a);
        case (a)
            2'd0: return m_cmp0;
            2'd1: return m_cmp1;
            2'd2: return {{(W-2){1'b0}}, m_mask, m_run};
            default: return m_cnt;
        endcase
    endfunction

    always @(posedge clk) begin : model
        logic [W-1:0] c0, c1;
        logic run, mask, h0, h1;
        if (!rst_n) begin
            m_cmp0 = '1; m_cmp1 = '1; m_buf0 = '1; m_buf1 = '1; m_cnt = '0;
            m_run = 0; m_mask = 0; m_tog = 0; m_irq0 = 0; m_irq1 = 0;
        end else begin
            c0 = m_cmp0; c1 = m_cmp1; run = m_run; mask = m_mask;
            if (wr_en) begin
                case (wr_addr)
                    2'd0: m_cmp0 = wr_data;
                    2'd1: m_cmp1 = wr_data;
                    2'd2: begin m_run = wr_data[0]; m_mask = wr_data[1]; end
                    default: ;
                endcase
            end
            if (!run) begin
                m_cnt = '0; m_tog = 0; m_irq0 = 0; m_irq1 = 0; m_buf0 = c0; m_buf1 = c1;
            end else if (cnt_en) begin
                h0 = (m_cnt == m_buf0);
                h1 = (m_cnt == m_buf1);
                m_irq0 = h0;
                m_irq1 = h1 && !mask;
                m_tog  = m_tog ^ h1;
                m_cnt  = h0 ? '0 : m_cnt + 1'b1;
                if (h0) begin m_buf0 = c0; m_buf1 = c1; end
            end else begin
                m_irq0 = 0; m_irq1 = 0;
            end
        end
    end

    always @(posedge clk) begin
        #2;
        if (rst_n && chk_on) begin
            chk(toggle_out === m_tog, "R5 R9 toggle_out", int'(toggle_out), int'(m_tog));
            chk(irq_period === m_irq0, "R3 R4 R11 irq_period", int'(irq_period), int'(m_irq0));
            chk(irq_cmp1 === m_irq1, "R6 R8 irq_cmp1", int'(irq_cmp1), int'(m_irq1));
            chk(rd_data === exp_read(rd_addr), "R1 R2 R10 rd_data", int'(rd_data), int'(exp_read(rd_addr)));
            if (win) begin
                w_hi   += int'(toggle_out);
                w_p    += int'(irq_period);
                w_c1   += int'(irq_cmp1);
                w_flip += int'(toggle_out != prev_tog);
            end
            prev_tog = toggle_out;
        end
    end

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic window(input int n);
        @(negedge clk);
        w_hi = 0; w_p = 0; w_c1 = 0; w_flip = 0; win = 1'b1;
        repeat (n) @(negedge clk);
        win = 1'b0;
    endtask

    initial begin
        #1600000;
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk_on = 1'b1;

        // R10: reset values
        rd_addr = 2'd0;
        @(posedge clk); #2;
        chk(rd_data == 8'hFF, "R10 period reset", int'(rd_data), 255);
        @(negedge clk); rd_addr = 2'd2;
        @(posedge clk); #2;
        chk(rd_data == 8'h00, "R10 control reset", int'(rd_data), 0);

        // R2: interval of P+1 counts
        cnt_en = 1'b1;
        rd_addr = 2'd3;
        wr(2'd0, 8'd5);
        wr(2'd1, 8'hFF);
        wr(2'd2, 8'd1);
        repeat (10) @(negedge clk);
        window(60);
        chk(w_p == 10, "R2 period pulses in 60 cycles", w_p, 10);
        chk(w_c1 == 0, "R6 unused match quiet", w_c1, 0);

        // R7: equal compares give 50% duty
        wr(2'd2, 8'd0);
        wr(2'd0, 8'd3);
        wr(2'd1, 8'd3);
        wr(2'd2, 8'd1);
        repeat (8) @(negedge clk);
        window(80);
        chk(w_hi == 40, "R7 high cycles of 80", w_hi, 40);

        // R8: mask stops only the match pulse
        wr(2'd2, 8'd3);
        repeat (4) @(negedge clk);
        window(40);
        chk(w_c1 == 0, "R8 masked pulses", w_c1, 0);
        chk(w_flip == 10, "R8 toggles under mask", w_flip, 10);

        // R9: stop clears counter and toggle
        wr(2'd2, 8'd0);
        @(posedge clk); #2;
        chk(rd_data == 0 && toggle_out == 0, "R9 stopped state", int'(rd_data) + int'(toggle_out), 0);

        // R11: enable low holds counter
        wr(2'd0, 8'd9);
        wr(2'd2, 8'd1);
        repeat (4) @(negedge clk);
        cnt_en = 1'b0;
        @(posedge clk); #2;
        begin
            int held;
            held = int'(rd_data);
            repeat (5) @(posedge clk);
            #2;
            chk(int'(rd_data) == held, "R11 counter held", int'(rd_data), held);
        end

        // random phase
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            cnt_en  = ($urandom % 4) != 0;
            rd_addr = 2'($urandom % 4);
            wr_en   = ($urandom % 20) == 0;
            wr_addr = 2'($urandom % 3);
            if (wr_addr == 2'd2)
                wr_data = {6'd0, 1'($urandom % 2), 1'(($urandom % 8) != 0)};
            else if (($urandom % 6) == 0)
                wr_data = 8'hFF;
            else
                wr_data = 8'($urandom % 12);
        end
        @(negedge clk);
        wr_en = 1'b0;
        repeat (4) @(negedge clk);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule